// File: doc/BRIEF.md
# Interprocessor and Interval-Timer Interrupt Controller

This block keeps the per-CPU interrupt flags of a four-processor system in one 64-bit control word, together with two arbitration lock fields that software manipulates with bit-level write rules. Any CPU can raise or drop another CPU's interprocessor interrupt by writing that word. A read of the word also returns the index of the CPU that issued the read in its two lowest bits.

A shared periodic tick drives the interval-timer interrupts. Each CPU owns a down-counter that thins this tick. The counter decrements on each rising tick, and once it passes zero a sticky overflow bit is set and that CPU's timer flag rises. Software reloads a counter to choose how many ticks to skip. It clears a timer flag by writing the control word. The tick input is synchronised and edge-detected inside the block.

Top module: `ipi_timer_ctl`

## Requirements
- R1: A read at offset 0x080 returns the stored control word ORed with `req_cpu` in bits 1:0. The word resets to 0x8_0000_0000, so no interrupt output is active after reset.
- R2: A write at offset 0x080 clears every stored bit in mask 0x1000_0FF0 whose write-data bit is 1.
- R3: If write bit 20 is 1, stored bits 23:16 become zero. Otherwise write bits 23:20 are ORed into bits 23:20, and write bits 19:16 are ORed into bits 19:16 only when stored bits 19:16 were all zero before the write.
- R4: Write bits 15:12 set stored bits 11:8. Set takes precedence over the clear of R2 in the same write. Stored bit 8+i is `ipi_irq[i]`.
- R5: Stored bit 4+i is `timer_irq[i]`. A control-word write can only clear it, never set it.
- R6: Stored bits 43:40 take write bits 43:40 on every control-word write. Bit 35 keeps its reset value.
- R7: Counter offsets are 0x380 (CPU0), 0x3C0 (CPU1), 0x700 (CPU2) and 0x740 (CPU3). A write stores write bits 23:0 and clears overflow bit 24. A read returns the 25-bit counter zero-extended.
- R8: On each rising edge of `tick_in`, every CPU whose `cpu_present` bit is 1 has its counter value c replaced by {c[24] | d[24], d[23:0]}, where d = (c − 1) mod 2^25. Counters of absent CPUs hold their value.
- R9: When bit 24 of a counter is 1 after a decrement, that CPU's timer flag (bit 4+i) is set.
- R10: A falling edge of `tick_in`, or a level held for many cycles, causes no decrement.
- R11: A counter write in the same cycle as that counter's tick decrement wins. The counter takes the written value, and that tick sets no timer flag for that CPU. The other counters still decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Write strobe for the CSR port |
| csr_addr | input | 12 | CSR byte offset |
| csr_wdata | input | 64 | CSR write data |
| csr_rdata | output | 64 | CSR read data (combinational from `csr_addr`) |
| req_cpu | input | 2 | Index of the CPU issuing the access |
| cpu_present | input | 4 | Which CPUs exist; absent ones never decrement |
| tick_in | input | 1 | Asynchronous periodic timer tick |
| ipi_irq | output | 4 | Interprocessor interrupt per CPU |
| timer_irq | output | 4 | Interval-timer interrupt per CPU |

## Verification
The decrement caused by a tick and a software reload of the same counter can land on the same clock edge. The bench raises `tick_in`, counts the two synchroniser stages to find the cycle in which the internal edge pulse is high, and holds a counter write in exactly that cycle. It then reads every counter. The written counter must hold the written value with overflow clear and no new timer flag. The other present counters must show exactly one decrement.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  localparam int NCPU    = 4;
  localparam int CNT_W   = 24;
  localparam int CNT_FW  = CNT_W + 1;
  localparam int DATA_W  = 64;
  localparam int ADDR_W  = 12;
  localparam logic [ADDR_W-1:0] CTRL_OFS   = 12'h080;
  localparam logic [DATA_W-1:0] CTRL_RESET = 64'h0000_0008_0000_0000;
  localparam logic [DATA_W-1:0] CLR_MASK   = 64'h0000_0000_1000_0FF0;

  // Byte offset of a CPU's ignore counter
  function automatic logic [ADDR_W-1:0] ign_offset(input int idx);
    case (idx)
      0:       return 12'h380;
      1:       return 12'h3C0;
      2:       return 12'h700;
      default: return 12'h740;
    endcase
  endfunction

  // One tick of an ignore counter: wrap in 25 bits, keep bit 24 sticky
  function automatic logic [CNT_FW-1:0] ign_dec(input logic [CNT_FW-1:0] c);
    logic [CNT_FW-1:0] d;
    d = c - 25'd1;
    return {c[CNT_W] | d[CNT_W], d[CNT_W-1:0]};
  endfunction

  // Control-word update for a software write
  function automatic logic [DATA_W-1:0] ctrl_apply(input logic [DATA_W-1:0] cur,
                                                   input logic [DATA_W-1:0] w);
    logic [DATA_W-1:0] n;
    n = cur & ~(w & CLR_MASK);
    if (w[20]) begin
      n[23:16] = 8'h00;
    end else begin
      n[23:20] = n[23:20] | w[23:20];
      if (cur[19:16] == 4'h0) n[19:16] = w[19:16];
    end
    n[11:8]  = n[11:8] | w[15:12];
    n[43:40] = w[43:40];
    return n;
  endfunction
endpackage

// File: rtl/ipt_tick_sync.sv
module ipt_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_async,
  output logic tick_rise
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], tick_async};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign tick_rise = sync_q[STAGES-1] & ~prev_q;

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_rise |=> !tick_rise); // R10
endmodule

// File: rtl/ipt_ign_counter.sv
module ipt_ign_counter
  import ipt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [CNT_W-1:0]  wr_val,
  input  logic              dec_en,
  output logic [CNT_FW-1:0] cnt,
  output logic              ovf_evt
);
  logic [CNT_FW-1:0] dec_val;
  logic              dec_take;

  assign dec_val  = ign_dec(cnt);
  assign dec_take = dec_en & ~wr_hit;
  assign ovf_evt  = dec_take & dec_val[CNT_W];

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (wr_hit)   cnt <= {1'b0, wr_val};
    else if (dec_take) cnt <= dec_val;
  end

  AST_WR_CLEARS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> !cnt[CNT_W]); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[CNT_W] && !wr_hit) |=> cnt[CNT_W]); // R8
  AST_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && dec_en) |-> !ovf_evt); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && !dec_en) |=> $stable(cnt)); // R10
endmodule

// File: rtl/ipt_ctrl_reg.sv
module ipt_ctrl_reg
  import ipt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NCPU-1:0]   iti_set,
  output logic [DATA_W-1:0] ctrl
);
  logic [DATA_W-1:0] after_wr;

  assign after_wr = wr_hit ? ctrl_apply(ctrl, wdata) : ctrl;

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl <= CTRL_RESET;
    else        ctrl <= after_wr | {{(DATA_W-8){1'b0}}, iti_set, 4'h0};
  end

  AST_ARB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wdata[20]) |=> (ctrl[23:16] == 8'h00)); // R3
  AST_IPI_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> ((ctrl[11:8] & $past(wdata[15:12])) == $past(wdata[15:12]))); // R4
  AST_ITI_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (iti_set == '0) |=> ((ctrl[7:4] & ~$past(ctrl[7:4])) == 4'h0)); // R5
  AST_ITI_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (iti_set != '0) |=> ((ctrl[7:4] & $past(iti_set)) == $past(iti_set))); // R9
  AST_REV_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 ctrl[35]); // R6
endmodule

// File: rtl/ipi_timer_ctl.sv
module ipi_timer_ctl
  import ipt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  input  logic [1:0]        req_cpu,
  input  logic [NCPU-1:0]   cpu_present,
  input  logic              tick_in,
  output logic [NCPU-1:0]   ipi_irq,
  output logic [NCPU-1:0]   timer_irq
);
  logic              tick_rise;
  logic              ctrl_wr_hit;
  logic [DATA_W-1:0] ctrl;
  logic [NCPU-1:0]   cnt_wr_hit;
  logic [NCPU-1:0]   ovf_evt;
  logic [CNT_FW-1:0] cnt_q [NCPU];

  ipt_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .tick_async(tick_in), .tick_rise(tick_rise));

  assign ctrl_wr_hit = csr_wr && (csr_addr == CTRL_OFS);

  for (genvar g = 0; g < NCPU; g++) begin : g_cnt
    assign cnt_wr_hit[g] = csr_wr && (csr_addr == ign_offset(g));
    ipt_ign_counter u_cnt (
      .clk(clk), .rst_n(rst_n),
      .wr_hit(cnt_wr_hit[g]),
      .wr_val(csr_wdata[CNT_W-1:0]),
      .dec_en(tick_rise & cpu_present[g]),
      .cnt(cnt_q[g]),
      .ovf_evt(ovf_evt[g]));
  end

  ipt_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_hit(ctrl_wr_hit), .wdata(csr_wdata),
    .iti_set(ovf_evt), .ctrl(ctrl));

  always_comb begin
    csr_rdata = '0;
    if (csr_addr == CTRL_OFS) csr_rdata = ctrl | {{(DATA_W-2){1'b0}}, req_cpu};
    for (int i = 0; i < NCPU; i++) begin
      if (csr_addr == ign_offset(i))
        csr_rdata = {{(DATA_W-CNT_FW){1'b0}}, cnt_q[i]};
    end
  end

  assign ipi_irq   = ctrl[11:8];
  assign timer_irq = ctrl[7:4];

  AST_ABSENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_present[0] && !cnt_wr_hit[0]) |=> $stable(cnt_q[0])); // R8
  AST_CPU_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == CTRL_OFS) |-> (csr_rdata[1:0] == req_cpu)); // R1
endmodule

// File: tb/ipi_timer_ctl_bench.sv
module ipi_timer_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr = 1'b0;
  logic [11:0] csr_addr = 12'h0;
  logic [63:0] csr_wdata = 64'h0;
  logic [63:0] csr_rdata;
  logic [1:0]  req_cpu = 2'd0;
  logic [3:0]  cpu_present = 4'b1011;
  logic        tick_in = 1'b0;
  logic [3:0]  ipi_irq, timer_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [63:0] m_ctrl;
  logic [24:0] m_cnt [4];

  always #2 clk = ~clk;

  ipi_timer_ctl u_ipi_timer_ctl (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .req_cpu(req_cpu),
    .cpu_present(cpu_present), .tick_in(tick_in),
    .ipi_irq(ipi_irq), .timer_irq(timer_irq));

  function automatic logic [11:0] cnt_addr(input int i);
    logic [11:0] t [4] = '{12'h380, 12'h3C0, 12'h700, 12'h740};
    return t[i];
  endfunction

  // Bench-side write model, field by field
  function automatic logic [63:0] m_write(input logic [63:0] cur, input logic [63:0] w);
    logic [63:0] r;
    r = cur;
    for (int b = 4; b < 12; b++) if (w[b]) r[b] = 1'b0;
    if (w[28]) r[28] = 1'b0;
    if (w[20]) r[23:16] = 8'h00;
    else begin
      for (int b = 20; b < 24; b++) if (w[b]) r[b] = 1'b1;
      if (cur[19:16] == 4'h0) r[19:16] = w[19:16];
    end
    for (int i = 0; i < 4; i++) if (w[12+i]) r[8+i] = 1'b1;
    r[43:40] = w[43:40];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    csr_addr = a; csr_wdata = d; csr_wr = 1'b1;
    @(negedge clk);
    csr_wr = 1'b0;
    if (a == 12'h080) m_ctrl = m_write(m_ctrl, d);
    for (int i = 0; i < 4; i++) if (a == cnt_addr(i)) m_cnt[i] = {1'b0, d[23:0]};
  endtask

  task automatic rd(input logic [11:0] a, input logic [1:0] cpu, output logic [63:0] v);
    @(negedge clk);
    csr_addr = a; req_cpu = cpu;
    #1 v = csr_rdata;
  endtask

  task automatic model_tick(input logic [3:0] skip);
    for (int i = 0; i < 4; i++) begin
      if (cpu_present[i] && !skip[i]) begin
        logic [24:0] d;
        d = m_cnt[i] - 25'd1;
        m_cnt[i] = {m_cnt[i][24] | d[24], d[23:0]};
        if (m_cnt[i][24]) m_ctrl[4+i] = 1'b1;
      end
    end
  endtask

  task automatic check_all(input string tag);
    logic [63:0] v;
    rd(12'h080, 2'd2, v);
    chk({tag, " ctrl"}, v, m_ctrl | 64'd2);
    chk({tag, " irq"}, {56'd0, ipi_irq, timer_irq}, {56'd0, m_ctrl[11:4]});
    for (int i = 0; i < 4; i++) begin
      rd(cnt_addr(i), 2'd0, v);
      chk({tag, " cnt"}, v, {39'd0, m_cnt[i]});
    end
  endtask

  task automatic do_tick(input string tag);
    logic [63:0] v;
    @(negedge clk); tick_in = 1'b1;
    repeat (6) @(negedge clk);
    model_tick(4'b0000);
    check_all({tag, " R8 R9 rise"});
    tick_in = 1'b0;
    repeat (6) @(negedge clk);
    rd(cnt_addr(0), 2'd0, v);
    chk({tag, " R10 fall"}, v, {39'd0, m_cnt[0]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    m_ctrl = 64'h8_0000_0000;
    for (int i = 0; i < 4; i++) m_cnt[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset value and requester index
    for (int c = 0; c < 4; c++) begin
      rd(12'h080, 2'(c), v);
      chk("R1 reset read", v, 64'h8_0000_0000 | 64'(c));
    end
    chk("R1 reset irq", {56'd0, ipi_irq, timer_irq}, 64'd0);

    // R6 read/write field, bit 35 kept
    wr(12'h080, 64'h0000_0A00_0000_0000);
    check_all("R6 rw field set");
    wr(12'h080, 64'h0000_0000_0000_0000);
    check_all("R6 rw field clear");

    // R4 IPI set, R2 clear, set beats clear
    wr(12'h080, 64'h5000);
    chk("R4 ipi set", {60'd0, ipi_irq}, 64'h5);
    wr(12'h080, 64'h0100);
    chk("R2 ipi clear", {60'd0, ipi_irq}, 64'h4);
    wr(12'h080, 64'h4400);
    chk("R4 set wins", {60'd0, ipi_irq}, 64'h4);
    check_all("R2 R4 state");

    // R3 arbitration sweep
    for (int a = 0; a < 16; a++) begin
      for (int w = 0; w < 16; w++) begin
        wr(12'h080, 64'h0010_0000);
        wr(12'h080, 64'(a) << 16);
        wr(12'h080, (64'(w) << 16) | (64'(w & 14) << 20));
        rd(12'h080, 2'd1, v);
        chk("R3 arb sweep", v, m_ctrl | 64'd1);
        chk("R3 arb calc", {56'd0, v[23:16]},
            {56'd0, 4'(w & 14), (a == 0) ? 4'(w) : 4'(a)});
      end
    end
    wr(12'h080, 64'h0010_0000);
    chk("R3 acl clear", m_ctrl[23:16], 64'd0);

    // R7 counter write truncation
    wr(12'h380, 64'hFFFF_FFFF_FF00_0002);
    check_all("R7 write truncates");

    // R8 R9 decrement, wrap, sticky, absent CPU 2
    wr(12'h3C0, 64'h0);
    wr(12'h700, 64'h0);
    wr(12'h740, 64'h5);
    do_tick("t1");
    chk("R9 cpu1 iti", {60'd0, timer_irq}, 64'h2);
    do_tick("t2");
    do_tick("t3");
    chk("R9 cpu0 iti", {60'd0, timer_irq}, 64'h3);
    chk("R8 sticky", {63'd0, m_cnt[1][24]}, 64'd1);

    // R5 software cannot set ITI; write clears it
    wr(12'h080, 64'h0F00_0000);
    check_all("R5 no sw set");
    wr(12'h080, 64'h0010);
    chk("R5 clear iti0", {60'd0, timer_irq}, 64'h2);
    check_all("R5 state");

    // R7 write clears overflow
    wr(12'h3C0, 64'h3);
    check_all("R7 ovf cleared");

    // R11 counter write lands with tick pulse
    wr(12'h080, 64'h00F0);
    wr(12'h740, 64'h0);
    @(negedge clk); tick_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    csr_addr = 12'h740; csr_wdata = 64'h10; csr_wr = 1'b1;
    @(negedge clk);
    csr_wr = 1'b0;
    m_cnt[3] = 25'h10;
    model_tick(4'b1000);
    repeat (4) @(negedge clk);
    check_all("R11 collide");
    chk("R11 no iti3", {63'd0, timer_irq[3]}, 64'd0);
    tick_in = 1'b0;
    repeat (6) @(negedge clk);
    check_all("R10 after fall");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule